// File: doc/BRIEF.md
# Banked Error Status Capture Register

This block keeps the error record of a memory-system resource controller. Internal checkers report an error with a one-cycle strobe that carries a security bit, a 4-bit error code, an 8-bit monitoring group, a 16-bit partition-or-monitor index, a 4-bit resource instance selector, and flags that say which of those fields the error actually carries. The security bit chooses one of two fully separate records: one for secure errors and one for non-secure errors. Each record keeps the newest error. A sticky overwrite flag shows that an earlier error was lost before software cleared it.

Software reaches each record through a simple register bus. A frame-select bit chooses the secure or the non-secure frame, and the register sits at byte offset 0xF8 in both frames. Reads return data one cycle after the request. Software reads the record and then writes zeros to clear it. A build option selects a 32-bit or a 64-bit register layout, and only the 64-bit layout holds the selector field. A second build option turns the register into read-as-zero with writes ignored, for controllers that report no errors.

Top module: `err_status_banked`

## Requirements
- R1: An accepted error is stored in the bank chosen by `err_secure` (1 = secure). The code goes to bits [27:24], the group to [23:16] and the index to [15:0]. A read of that bank returns the new value.
- R2: If an error is accepted while the bank's stored code is non-zero, bit 31 (overwrite) becomes 1 and the bank holds the newest error. Hardware never leaves overwrite = 1 with code = 0 unless software wrote that state.
- R3: If an error is accepted while the stored code is 0, bit 31 becomes 0. This holds even when software had set bit 31.
- R4: When `err_has_group` is 0, the group field is stored as 0. When `err_has_index` is 0, the index field is stored as 0.
- R5: In the 64-bit layout, the selector is stored in bits [35:32] when `err_has_sel` is 1 and as 0 otherwise. Bits [63:36] and [30:28] always read 0.
- R6: The two banks are independent: an error or a write for one bank never changes the other. Both banks are at offset 0xF8, and `reg_secure` selects the frame.
- R7: A software write at offset 0xF8 replaces the overwrite, code, group, index and selector fields with the written bits. Writing zeros clears the record. Reserved bits written as 1 read back as 0.
- R8: If a capture and a software write hit the same bank in one cycle, the capture wins. Its overwrite bit follows the stored code before that cycle. A write to the other bank in the same cycle still takes effect.
- R9: An error with code 0 or 12–15 is ignored. Codes 8–11 are accepted only when the selector option is built in.
- R10: `reg_rvalid` is 1 exactly in the cycle after a read request. A read at any offset other than 0xF8 returns 0, and a write at any other offset changes nothing.
- R11: After reset, both banks read 0.
- R12: With `ERR_ENABLED` = 0, every read returns 0 and neither errors nor writes change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | One-cycle error strobe |
| err_secure | input | 1 | Bank of the error (1 = secure) |
| err_code | input | 4 | Error code |
| err_group | input | 8 | Monitoring group |
| err_index | input | 16 | Partition ID or monitor index |
| err_sel | input | 4 | Resource instance selector |
| err_has_group | input | 1 | Error carries a group |
| err_has_index | input | 1 | Error carries an index |
| err_has_sel | input | 1 | Error carries a selector |
| reg_req | input | 1 | Bus request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_secure | input | 1 | Frame select (1 = secure) |
| reg_addr | input | ADDR_W | Byte offset in the frame |
| reg_wdata | input | DATA_W | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | DATA_W | Read data |

## Verification
A hardware capture and a software write can land on the same bank in the same clock cycle. The bench provokes this by driving an error strobe and a clearing write into the secure bank on one edge. It then expects the new error to remain, with its overwrite flag taken from the code stored before that edge. The bench also pairs a non-secure capture with a secure write in one cycle and checks that both take effect.

// File: rtl/esr_pkg.sv
package esr_pkg;
  localparam int CODE_W = 4;
  localparam int GRP_W  = 8;
  localparam int IDX_W  = 16;
  localparam int SEL_W  = 4;
  localparam int WORD_W = 64;
  localparam logic [CODE_W-1:0] CODE_BASIC_LAST = 4'd7;
  localparam logic [CODE_W-1:0] CODE_SEL_FIRST  = 4'd8;
  localparam logic [CODE_W-1:0] CODE_SEL_LAST   = 4'd11;

  typedef struct packed {
    logic              ovr;
    logic [CODE_W-1:0] code;
    logic [GRP_W-1:0]  grp;
    logic [IDX_W-1:0]  idx;
    logic [SEL_W-1:0]  sel;
  } esr_rec_t;

  function automatic logic [WORD_W-1:0] esr_pack(esr_rec_t r);
    return {28'd0, r.sel, r.ovr, 3'd0, r.code, r.grp, r.idx};
  endfunction

  function automatic esr_rec_t esr_unpack(logic [WORD_W-1:0] w, logic keep_sel);
    esr_rec_t r;
    r.ovr  = w[31];
    r.code = w[27:24];
    r.grp  = w[23:16];
    r.idx  = w[15:0];
    r.sel  = keep_sel ? w[35:32] : '0;
    return r;
  endfunction
endpackage

// File: rtl/esr_capture_filter.sv
module esr_capture_filter
  import esr_pkg::*;
#(
  parameter bit SEL_EN = 1'b1
) (
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [GRP_W-1:0]  evt_grp,
  input  logic [IDX_W-1:0]  evt_idx,
  input  logic [SEL_W-1:0]  evt_sel,
  input  logic              evt_has_grp,
  input  logic              evt_has_idx,
  input  logic              evt_has_sel,
  output logic              accept,
  output esr_rec_t          rec
);
  logic basic_ok, sel_ok;

  always_comb begin
    basic_ok = (evt_code != '0) && (evt_code <= CODE_BASIC_LAST);
    sel_ok   = SEL_EN && (evt_code >= CODE_SEL_FIRST) && (evt_code <= CODE_SEL_LAST);
    accept   = evt_valid && (basic_ok || sel_ok);
    rec.ovr  = 1'b0;
    rec.code = evt_code;
    rec.grp  = evt_has_grp ? evt_grp : '0;
    rec.idx  = evt_has_idx ? evt_idx : '0;
    rec.sel  = (SEL_EN && evt_has_sel) ? evt_sel : '0;
  end

  // R9: zero and reserved codes never pass the filter
  always_comb begin
    p_reserved_code_dropped_r9: assert (!(accept && (evt_code == '0 || evt_code > CODE_SEL_LAST)));
  end
endmodule

// File: rtl/esr_bank.sv
module esr_bank
  import esr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cap_en,
  input  esr_rec_t cap_rec,
  input  logic     wr_en,
  input  esr_rec_t wr_rec,
  output esr_rec_t rec_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q <= '0;
    end else if (cap_en) begin
      rec_q     <= cap_rec;
      rec_q.ovr <= (rec_q.code != '0);
    end else if (wr_en) begin
      rec_q <= wr_rec;
    end
  end

  p_ovr_on_repeat_r2: assert property (@(posedge clk) disable iff (rst)
    cap_en && (rec_q.code != '0) |=> rec_q.ovr && (rec_q.code == $past(cap_rec.code)));

  p_no_hw_ovr_hole_r2: assert property (@(posedge clk) disable iff (rst)
    !wr_en && !(rec_q.ovr && rec_q.code == '0) |=> !(rec_q.ovr && rec_q.code == '0));

  p_clean_first_r3: assert property (@(posedge clk) disable iff (rst)
    cap_en && (rec_q.code == '0) |=> !rec_q.ovr);

  p_capture_wins_r8: assert property (@(posedge clk) disable iff (rst)
    cap_en && wr_en |=> (rec_q.code == $past(cap_rec.code)) && (rec_q.idx == $past(cap_rec.idx)));

  p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !cap_en && !wr_en |=> $stable(rec_q));
endmodule

// File: rtl/esr_read_port.sv
module esr_read_port
  import esr_pkg::*;
#(
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h0F8,
  parameter int              DATA_W     = 64,
  parameter bit              ENABLED    = 1'b1,
  parameter int              NUM_BANKS  = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         rd_req,
  input  logic                         rd_secure,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [NUM_BANKS-1:0][WORD_W-1:0] bank_words,
  output logic                         rvalid,
  output logic [DATA_W-1:0]            rdata
);
  logic [WORD_W-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    if (ENABLED && rd_addr == REG_OFFSET) sel_word = bank_words[rd_secure];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_req;
      if (rd_req) rdata <= sel_word[DATA_W-1:0];
    end
  end

  p_rvalid_latency_r10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rvalid);

  p_rvalid_only_after_read_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rvalid);

  p_reserved_mid_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rdata[30:28] == 3'd0);

  generate
    if (DATA_W > 36) begin : g_wide_chk
      p_reserved_top_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rdata[DATA_W-1:36] == '0);
    end
    if (!ENABLED) begin : g_off_chk
      p_raz_r12: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rdata == '0);
    end
  endgenerate
endmodule

// File: rtl/err_status_banked.sv
module err_status_banked
  import esr_pkg::*;
#(
  parameter bit              EXT_LAYOUT  = 1'b1,
  parameter bit              HAS_SEL     = 1'b1,
  parameter bit              ERR_ENABLED = 1'b1,
  parameter int              ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 12'h0F8,
  localparam int             DATA_W      = EXT_LAYOUT ? 64 : 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic              err_secure,
  input  logic [3:0]        err_code,
  input  logic [7:0]        err_group,
  input  logic [15:0]       err_index,
  input  logic [3:0]        err_sel,
  input  logic              err_has_group,
  input  logic              err_has_index,
  input  logic              err_has_sel,
  input  logic              reg_req,
  input  logic              reg_write,
  input  logic              reg_secure,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rvalid,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int  NUM_BANKS = 2;
  localparam bit  SEL_EN    = EXT_LAYOUT && HAS_SEL;

  logic                              cap_ok;
  esr_rec_t                          cap_rec;
  esr_rec_t                          wr_rec;
  logic [WORD_W-1:0]                 wdata_w;
  logic                              wr_hit;
  logic [NUM_BANKS-1:0][WORD_W-1:0]  bank_words;

  always_comb begin
    wdata_w              = '0;
    wdata_w[DATA_W-1:0]  = reg_wdata;
    wr_rec               = esr_unpack(wdata_w, SEL_EN);
    wr_hit               = ERR_ENABLED && reg_req && reg_write && (reg_addr == REG_OFFSET);
  end

  esr_capture_filter #(.SEL_EN(SEL_EN)) u_filter (
    .evt_valid   (err_valid),
    .evt_code    (err_code),
    .evt_grp     (err_group),
    .evt_idx     (err_index),
    .evt_sel     (err_sel),
    .evt_has_grp (err_has_group),
    .evt_has_idx (err_has_index),
    .evt_has_sel (err_has_sel),
    .accept      (cap_ok),
    .rec         (cap_rec)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      esr_rec_t rec_q;
      logic     cap_en, wr_en;
      always_comb begin
        cap_en = ERR_ENABLED && cap_ok && (err_secure == b[0]);
        wr_en  = wr_hit && (reg_secure == b[0]);
      end
      esr_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .cap_rec (cap_rec),
        .wr_en   (wr_en),
        .wr_rec  (wr_rec),
        .rec_q   (rec_q)
      );
      assign bank_words[b] = esr_pack(rec_q);
    end
  endgenerate

  esr_read_port #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET),
    .DATA_W     (DATA_W),
    .ENABLED    (ERR_ENABLED),
    .NUM_BANKS  (NUM_BANKS)
  ) u_read (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (reg_req && !reg_write),
    .rd_secure  (reg_secure),
    .rd_addr    (reg_addr),
    .bank_words (bank_words),
    .rvalid     (reg_rvalid),
    .rdata      (reg_rdata)
  );
endmodule

// File: tb/err_status_banked_bench.sv
`timescale 1ns/1ps
module err_status_banked_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_valid = 0, err_secure = 0, err_has_group = 0, err_has_index = 0, err_has_sel = 0;
  logic [3:0]  err_code = 0, err_sel = 0;
  logic [7:0]  err_group = 0;
  logic [15:0] err_index = 0;
  logic        reg_req = 0, reg_write = 0, reg_secure = 0;
  logic [11:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic        rvalid, off_rvalid;
  logic [63:0] rdata, off_rdata;

  typedef struct { logic [63:0] exp; string tag; } exp_t;
  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  err_status_banked u_err_status_banked (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_secure(err_secure),
    .err_code(err_code), .err_group(err_group), .err_index(err_index), .err_sel(err_sel),
    .err_has_group(err_has_group), .err_has_index(err_has_index), .err_has_sel(err_has_sel),
    .reg_req(reg_req), .reg_write(reg_write), .reg_secure(reg_secure), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rvalid(rvalid), .reg_rdata(rdata));

  err_status_banked #(.ERR_ENABLED(1'b0)) u_err_status_banked_off (
    .clk(clk), .rst(rst), .err_valid(err_valid), .err_secure(err_secure),
    .err_code(err_code), .err_group(err_group), .err_index(err_index), .err_sel(err_sel),
    .err_has_group(err_has_group), .err_has_index(err_has_index), .err_has_sel(err_has_sel),
    .reg_req(reg_req), .reg_write(reg_write), .reg_secure(reg_secure), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rvalid(off_rvalid), .reg_rdata(off_rdata));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // monitor: pops the scoreboard as read data appears
  always @(negedge clk) begin
    exp_t e;
    if (!rst) begin
      if (rvalid) begin
        if (exp_q.size() == 0) check("R10 unexpected rvalid", 64'd1, 64'd0);
        else begin
          e = exp_q.pop_front();
          check(e.tag, rdata, e.exp);
        end
      end
      if (off_rvalid) check("R12 disabled copy reads zero", off_rdata, 64'd0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      check("watchdog expired", 64'd1, 64'd0);
      summary();
    end
  end

  task automatic set_err(logic sec, logic [3:0] code, logic [7:0] g, logic hg,
                         logic [15:0] ix, logic hi, logic [3:0] s, logic hs);
    err_valid = 1; err_secure = sec; err_code = code; err_group = g; err_has_group = hg;
    err_index = ix; err_has_index = hi; err_sel = s; err_has_sel = hs;
  endtask

  task automatic set_wr(logic sec, logic [11:0] a, logic [63:0] d);
    reg_req = 1; reg_write = 1; reg_secure = sec; reg_addr = a; reg_wdata = d;
  endtask

  task automatic set_rd(logic sec, logic [11:0] a, logic [63:0] exp, string tag);
    exp_t e;
    reg_req = 1; reg_write = 0; reg_secure = sec; reg_addr = a;
    e.exp = exp; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    err_valid = 0; err_has_group = 0; err_has_index = 0; err_has_sel = 0;
    reg_req = 0; reg_write = 0;
  endtask

  task automatic rd(logic sec, logic [63:0] exp, string tag);
    set_rd(sec, 12'h0F8, exp, tag);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    rd(1, 64'h0, "R11 secure after reset");
    rd(0, 64'h0, "R11 nonsecure after reset");
    step();
    check("R10 rvalid idle", {63'd0, rvalid}, 64'd0);

    // R1 capture into non-secure bank with all fields
    set_err(0, 4'd2, 8'h5A, 1, 16'h1234, 1, 4'h3, 1); step();
    rd(0, 64'h0000_0003_025A_1234, "R1 nonsecure capture");
    rd(1, 64'h0, "R6 secure untouched");

    // R2 / R4 / R5 second error overwrites, absent fields zeroed
    set_err(0, 4'd5, 8'hFF, 0, 16'h0007, 1, 4'hF, 0); step();
    rd(0, 64'h0000_0000_8500_0007, "R2 R4 R5 overwrite with zeroed fields");

    // R7 clear, then R3 fresh error has no overwrite
    set_wr(0, 12'h0F8, 64'h0); step();
    rd(0, 64'h0, "R7 cleared by write");
    set_err(0, 4'd1, 8'h11, 1, 16'h0022, 1, 4'h0, 0); step();
    rd(0, 64'h0000_0000_0111_0022, "R3 single error no overwrite");

    // R1 / R5 selector error into secure bank
    set_err(1, 4'd9, 8'h77, 0, 16'h5555, 0, 4'hA, 1); step();
    rd(1, 64'h0000_000A_0900_0000, "R1 R5 secure selector error");
    rd(0, 64'h0000_0000_0111_0022, "R6 nonsecure unchanged");

    // R9 ignored codes
    set_err(1, 4'hC, 8'h01, 1, 16'h0001, 1, 4'h1, 1); step();
    set_err(1, 4'h0, 8'h01, 1, 16'h0001, 1, 4'h1, 1); step();
    rd(1, 64'h0000_000A_0900_0000, "R9 reserved and zero codes ignored");

    // R7 reserved bits stored as zero
    set_wr(1, 12'h0F8, 64'hFFFF_FFFF_FFFF_FFFF); step();
    rd(1, 64'h0000_000F_8FFF_FFFF, "R7 R5 reserved bits read zero");

    // R3 software-written overwrite with zero code, then capture
    set_wr(1, 12'h0F8, 64'h0000_0000_8000_0000); step();
    rd(1, 64'h0000_0000_8000_0000, "R7 software state ovr without code");
    set_err(1, 4'd3, 8'h00, 0, 16'h0044, 1, 4'h0, 0); step();
    rd(1, 64'h0000_0000_0300_0044, "R3 capture after zero code clears ovr");

    // R8 collision on the same bank: capture wins
    set_err(1, 4'd4, 8'h22, 1, 16'h0000, 0, 4'h0, 0);
    set_wr(1, 12'h0F8, 64'h0); step();
    rd(1, 64'h0000_0000_8422_0000, "R8 capture beats same-cycle write");

    // R8 / R6 capture on one bank while the other bank is written
    set_err(0, 4'd6, 8'h00, 0, 16'h0099, 1, 4'h0, 0);
    set_wr(1, 12'h0F8, 64'h0); step();
    rd(0, 64'h0000_0000_8600_0099, "R8 nonsecure captured during secure write");
    rd(1, 64'h0, "R8 R6 secure write took effect");

    // R10 other offsets
    set_rd(0, 12'h0F0, 64'h0, "R10 other offset reads zero"); step();
    set_wr(1, 12'h0F0, 64'h0000_0000_0100_0000); step();
    rd(1, 64'h0, "R10 write at other offset ignored");

    step(); step();
    check("R10 all reads answered", exp_q.size(), 64'd0);
    summary();
  end
endmodule